// File: doc/BRIEF.md
# Codec Command and Response Ring Engine

This block sits on the controller side of an audio codec link. It carries commands from memory out to the codec and stores the codec's replies back in memory. Software places 32-bit command words in a command ring in memory and moves a write pointer forward. Each command word holds the codec address in bits 31:28, the node number in bits 27:20 and the verb with its payload in bits 19:0. While the command ring is running, the engine fetches the entry after its read pointer and hands it to the codec link. It then waits for that command's response before it fetches the next one.

Every response goes into a response ring in memory as a pair of words: the response data, then an extended word. The extended word marks responses the codec sent on its own (unsolicited) and records the codec address. Hardware moves the response write pointer forward. It raises an interrupt status once a programmed number of responses has been stored since the last time the status fired.

A plain request/acknowledge memory port stands in for system DMA. The codec link is a valid/ready pair for commands and a second valid/ready pair for responses. Ring sizes of 2, 16 or 256 entries are selected for each ring separately. Both pointers can be returned to zero by a reset control.

Top module: `crr_engine`

## Requirements
- R1: Each command word reaches `lnk_cmd` unchanged, in ring order, starting with the entry after the current read pointer. It is held stable while `lnk_cmd_valid` waits for `lnk_cmd_ready`.
- R2: `cmd_rp` changes only when a command is handed to the link. It then advances by one modulo the ring size. Fetching takes place only while `cmd_rp` differs from `cmd_wp` masked to the ring size.
- R3: Size select value 0 gives 2 entries, 1 gives 16 and 2 or 3 gives 256, for each ring independently. Pointers wrap at the selected size. `size_cap` reads 3'b111, where bit 2 means 256 entries, bit 1 means 16 and bit 0 means 2.
- R4: While `cmd_rp_rst` is high, `cmd_rp` is 0 and `cmd_rp_rst_busy` reads 1 from the next cycle on. After `cmd_rp_rst` falls, `cmd_rp_rst_busy` reads 0 one cycle later, because the pointer is then at zero.
- R5: At most one command is outstanding. No new command appears on the link until the solicited response to the previous one has been written to memory.
- R6: A response goes into slot s = (`rsp_wp`+1) modulo the ring size. The data word is written to word address RSP_BASE+2s and the extended word to RSP_BASE+2s+1. In the extended word, bit 4 is 1 for an unsolicited response and bits 3:0 carry the codec address. `rsp_wp` then becomes s.
- R7: A `rsp_wp_rst` pulse returns `rsp_wp` to 0 and restarts the response count.
- R8: `rsp_irq` rises when `rsp_int_cnt` responses (1 to 255) have been stored since the count last restarted. It stays high until a cycle with `rsp_irq_clr` high.
- R9: While `rsp_run` is low, no response is accepted from the link and nothing is written to the response ring.
- R10: While `cmd_run` is low, no command is fetched and none is sent, even if the ring holds pending entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_run | input | 1 | Command ring run control |
| cmd_size_sel | input | 2 | Command ring size select |
| cmd_wp | input | 8 | Software command write pointer |
| cmd_rp_rst | input | 1 | Command read pointer reset control |
| cmd_rp | output | 8 | Command read pointer |
| cmd_rp_rst_busy | output | 1 | Reset control readback |
| rsp_run | input | 1 | Response ring run control |
| rsp_size_sel | input | 2 | Response ring size select |
| rsp_wp_rst | input | 1 | Response write pointer reset pulse |
| rsp_wp | output | 8 | Response write pointer |
| rsp_int_cnt | input | 8 | Responses per interrupt |
| rsp_irq_clr | input | 1 | Write-1-to-clear for the response status |
| rsp_irq | output | 1 | Response interrupt status |
| size_cap | output | 3 | Supported ring sizes |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid with mem_ack |
| mem_ack | input | 1 | Memory acknowledge |
| lnk_cmd_valid | output | 1 | Command offered to codec link |
| lnk_cmd | output | 32 | Command word |
| lnk_cmd_ready | input | 1 | Link accepts command |
| lnk_rsp_valid | input | 1 | Response offered by codec link |
| lnk_rsp_data | input | 32 | Response data |
| lnk_rsp_unsol | input | 1 | Response is unsolicited |
| lnk_rsp_caddr | input | 4 | Codec address of the response |
| lnk_rsp_ready | output | 1 | Engine accepts response |

## Verification
The engine is first run with 256-entry rings and a short burst of commands, which shows that words pass through unchanged and that responses land in the right slots. It is then run with 2-entry rings, one command at a time, so that every step crosses the wrap point. The 16-entry run uses a burst longer than the ring, with an unsolicited response injected while commands are still in flight. That run tells correct wrapping apart from a stuck mask and checks that unsolicited traffic neither completes nor blocks the outstanding command. Stopping each ring while work is pending, and running the pointer reset controls between phases, separates the gating of fetch and store from the pointer logic itself.

// File: rtl/crr_pkg.sv
package crr_pkg;

    localparam int PTR_W     = 8;
    localparam int WORD_W    = 32;
    localparam int UNSOL_BIT = 4;
    localparam logic [2:0] SIZES_SUPPORTED = 3'b111;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_SEND,
        ST_WLO,
        ST_WHI
    } eng_state_e;

    typedef struct packed {
        logic [3:0]  caddr;
        logic [7:0]  node;
        logic [19:0] verb;
    } cmd_word_t;

    typedef struct packed {
        logic [WORD_W-1:0] data;
        logic              unsol;
        logic [3:0]        caddr;
    } rsp_entry_t;

    function automatic logic [PTR_W-1:0] ring_mask(input logic [1:0] sel);
        case (sel)
            2'd0:    return PTR_W'(8'h01);
            2'd1:    return PTR_W'(8'h0F);
            default: return PTR_W'(8'hFF);
        endcase
    endfunction

    function automatic logic [WORD_W-1:0] ext_word(input rsp_entry_t e);
        logic [WORD_W-1:0] w;
        w            = '0;
        w[UNSOL_BIT] = e.unsol;
        w[3:0]       = e.caddr;
        return w;
    endfunction

endpackage

// File: rtl/crr_cmd_ptr.sv
module crr_cmd_ptr
    import crr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             rp_rst_req,
    input  logic             advance,
    input  logic [PTR_W-1:0] mask,
    input  logic [PTR_W-1:0] sw_wp,
    output logic [PTR_W-1:0] rp,
    output logic [PTR_W-1:0] next_rp,
    output logic             rst_busy,
    output logic             pending
);
    logic [PTR_W-1:0] rp_q;
    logic             busy_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rp_q   <= '0;
            busy_q <= 1'b0;
        end else begin
            busy_q <= rp_rst_req | (busy_q & (rp_q != '0));
            if (rp_rst_req)
                rp_q <= '0;
            else if (advance)
                rp_q <= next_rp;
        end
    end

    assign next_rp  = (rp_q + PTR_W'(1)) & mask;
    assign pending  = (rp_q != (sw_wp & mask));
    assign rp       = rp_q;
    assign rst_busy = busy_q;

    // R4
    rp_rst_zero_chk: assert property (@(posedge clk) disable iff (rst)
        rp_rst_req |=> (rp == '0 && rst_busy));

    // R2
    rp_step_chk: assert property (@(posedge clk) disable iff (rst)
        (rp != $past(rp)) |-> (rp == '0 || rp == (($past(rp) + PTR_W'(1)) & $past(mask))));

endmodule

// File: rtl/crr_rsp_ptr.sv
module crr_rsp_ptr
    import crr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wp_rst,
    input  logic             store,
    input  logic [PTR_W-1:0] mask,
    input  logic [PTR_W-1:0] int_cnt,
    input  logic             irq_clr,
    output logic [PTR_W-1:0] wp,
    output logic [PTR_W-1:0] next_wp,
    output logic             irq
);
    logic [PTR_W-1:0] wp_q;
    logic [PTR_W-1:0] cnt_q;
    logic [PTR_W-1:0] cnt_inc;
    logic             irq_q;
    logic             hit;

    assign next_wp = (wp_q + PTR_W'(1)) & mask;
    assign cnt_inc = cnt_q + PTR_W'(1);
    assign hit     = store & ~wp_rst & (cnt_inc == int_cnt);

    always_ff @(posedge clk) begin
        if (rst) begin
            wp_q  <= '0;
            cnt_q <= '0;
            irq_q <= 1'b0;
        end else begin
            if (wp_rst) begin
                wp_q  <= '0;
                cnt_q <= '0;
            end else if (store) begin
                wp_q  <= next_wp;
                cnt_q <= hit ? '0 : cnt_inc;
            end
            if (hit)
                irq_q <= 1'b1;
            else if (irq_clr)
                irq_q <= 1'b0;
        end
    end

    assign wp  = wp_q;
    assign irq = irq_q;

    // R7
    wp_rst_zero_chk: assert property (@(posedge clk) disable iff (rst)
        wp_rst |=> (wp == '0));

    // R8
    irq_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (irq && !irq_clr) |=> irq);

endmodule

// File: rtl/crr_engine.sv
module crr_engine
    import crr_pkg::*;
#(
    parameter int AW       = 12,
    parameter int CMD_BASE = 'h000,
    parameter int RSP_BASE = 'h200
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_run,
    input  logic [1:0]        cmd_size_sel,
    input  logic [7:0]        cmd_wp,
    input  logic              cmd_rp_rst,
    output logic [7:0]        cmd_rp,
    output logic              cmd_rp_rst_busy,
    input  logic              rsp_run,
    input  logic [1:0]        rsp_size_sel,
    input  logic              rsp_wp_rst,
    output logic [7:0]        rsp_wp,
    input  logic [7:0]        rsp_int_cnt,
    input  logic              rsp_irq_clr,
    output logic              rsp_irq,
    output logic [2:0]        size_cap,
    output logic              mem_req,
    output logic              mem_we,
    output logic [AW-1:0]     mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic [31:0]       mem_rdata,
    input  logic              mem_ack,
    output logic              lnk_cmd_valid,
    output logic [31:0]       lnk_cmd,
    input  logic              lnk_cmd_ready,
    input  logic              lnk_rsp_valid,
    input  logic [31:0]       lnk_rsp_data,
    input  logic              lnk_rsp_unsol,
    input  logic [3:0]        lnk_rsp_caddr,
    output logic              lnk_rsp_ready
);
    eng_state_e       state;
    cmd_word_t        cmd_q;
    rsp_entry_t       rsp_q;
    logic             outstanding;
    logic             cmd_pending;
    logic             cmd_advance;
    logic             rsp_store;
    logic [PTR_W-1:0] next_rp;
    logic [PTR_W-1:0] next_wp;
    logic [AW-1:0]    rsp_slot_addr;

    assign cmd_advance = (state == ST_SEND) && lnk_cmd_ready;
    assign rsp_store   = (state == ST_WHI) && mem_ack;

    crr_cmd_ptr u_cmd_ptr (
        .clk        (clk),
        .rst        (rst),
        .rp_rst_req (cmd_rp_rst),
        .advance    (cmd_advance),
        .mask       (ring_mask(cmd_size_sel)),
        .sw_wp      (cmd_wp),
        .rp         (cmd_rp),
        .next_rp    (next_rp),
        .rst_busy   (cmd_rp_rst_busy),
        .pending    (cmd_pending)
    );

    crr_rsp_ptr u_rsp_ptr (
        .clk     (clk),
        .rst     (rst),
        .wp_rst  (rsp_wp_rst),
        .store   (rsp_store),
        .mask    (ring_mask(rsp_size_sel)),
        .int_cnt (rsp_int_cnt),
        .irq_clr (rsp_irq_clr),
        .wp      (rsp_wp),
        .next_wp (next_wp),
        .irq     (rsp_irq)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= ST_IDLE;
            outstanding <= 1'b0;
            cmd_q       <= '0;
            rsp_q       <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (rsp_run && lnk_rsp_valid) begin
                        rsp_q <= '{data: lnk_rsp_data, unsol: lnk_rsp_unsol, caddr: lnk_rsp_caddr};
                        state <= ST_WLO;
                    end else if (cmd_run && cmd_pending && !outstanding) begin
                        state <= ST_FETCH;
                    end
                end
                ST_FETCH: if (mem_ack) begin
                    cmd_q <= cmd_word_t'(mem_rdata);
                    state <= ST_SEND;
                end
                ST_SEND: if (lnk_cmd_ready) begin
                    outstanding <= 1'b1;
                    state       <= ST_IDLE;
                end
                ST_WLO: if (mem_ack) state <= ST_WHI;
                ST_WHI: if (mem_ack) begin
                    if (!rsp_q.unsol) outstanding <= 1'b0;
                    state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign rsp_slot_addr = AW'(RSP_BASE) + AW'({next_wp, 1'b0});

    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        case (state)
            ST_FETCH: begin
                mem_req  = 1'b1;
                mem_addr = AW'(CMD_BASE) + AW'(next_rp);
            end
            ST_WLO: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = rsp_slot_addr;
                mem_wdata = rsp_q.data;
            end
            ST_WHI: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = rsp_slot_addr + AW'(1);
                mem_wdata = ext_word(rsp_q);
            end
            default: ;
        endcase
    end

    assign lnk_cmd_valid = (state == ST_SEND);
    assign lnk_cmd       = cmd_q;
    assign lnk_rsp_ready = (state == ST_IDLE) && rsp_run;
    assign size_cap      = SIZES_SUPPORTED;

    // R1
    cmd_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (lnk_cmd_valid && !lnk_cmd_ready) |=> (lnk_cmd_valid && $stable(lnk_cmd)));

    // R5
    one_cmd_chk: assert property (@(posedge clk) disable iff (rst)
        lnk_cmd_valid |-> !outstanding);

    // R10
    stopped_no_fetch_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && !cmd_run) |=> (state != ST_FETCH));

    // R9
    rsp_stopped_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && !rsp_run) |=> (state != ST_WLO));

endmodule

// File: tb/sim_crr_engine.sv
module sim_crr_engine;
    localparam int CLK_NS     = 10;
    localparam int AW         = 12;
    localparam int CMD_BASE   = 'h000;
    localparam int RSP_BASE   = 'h200;
    localparam int LINK_LAT   = 4;
    localparam logic [3:0] UNSOL_ADDR = 4'd3;

    typedef struct packed {
        logic [AW-1:0] addr;
        logic [31:0]   data;
    } wr_t;

    typedef struct packed {
        logic [7:0]  slot;
        logic [31:0] data;
        logic [31:0] ext;
    } exp_rsp_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cmd_run = 1'b0, cmd_rp_rst = 1'b0, rsp_run = 1'b0, rsp_wp_rst = 1'b0, rsp_irq_clr = 1'b0;
    logic [1:0] cmd_size_sel = 2'd2, rsp_size_sel = 2'd2;
    logic [7:0] cmd_wp = 8'd0, rsp_int_cnt = 8'd1;
    logic [7:0] cmd_rp, rsp_wp;
    logic cmd_rp_rst_busy, rsp_irq;
    logic [2:0] size_cap;
    logic mem_req, mem_we, mem_ack;
    logic [AW-1:0] mem_addr;
    logic [31:0] mem_wdata, mem_rdata;
    logic lnk_cmd_valid, lnk_cmd_ready, lnk_rsp_valid, lnk_rsp_unsol, lnk_rsp_ready;
    logic [31:0] lnk_cmd, lnk_rsp_data;
    logic [3:0] lnk_rsp_caddr;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    logic [31:0] cmd_mem [0:255];
    logic [31:0] exp_cmds [$];
    logic [31:0] got_cmds [$];
    wr_t         wr_log [$];
    exp_rsp_t    exp_rsp [$];
    logic [7:0]  sw_wp = 8'd0;
    logic [7:0]  model_rp;
    logic [7:0]  model_wp;
    logic        model_out;
    int          unsol_reqs = 0;
    int          unsol_done;
    logic        lnk_busy;
    int          lat_cnt;
    logic [31:0] pend_cmd;

    always #(CLK_NS/2) clk = ~clk;

    crr_engine #(.AW(AW), .CMD_BASE(CMD_BASE), .RSP_BASE(RSP_BASE)) u0 (
        .clk(clk), .rst(rst),
        .cmd_run(cmd_run), .cmd_size_sel(cmd_size_sel), .cmd_wp(cmd_wp),
        .cmd_rp_rst(cmd_rp_rst), .cmd_rp(cmd_rp), .cmd_rp_rst_busy(cmd_rp_rst_busy),
        .rsp_run(rsp_run), .rsp_size_sel(rsp_size_sel), .rsp_wp_rst(rsp_wp_rst),
        .rsp_wp(rsp_wp), .rsp_int_cnt(rsp_int_cnt), .rsp_irq_clr(rsp_irq_clr),
        .rsp_irq(rsp_irq), .size_cap(size_cap),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ack(mem_ack),
        .lnk_cmd_valid(lnk_cmd_valid), .lnk_cmd(lnk_cmd), .lnk_cmd_ready(lnk_cmd_ready),
        .lnk_rsp_valid(lnk_rsp_valid), .lnk_rsp_data(lnk_rsp_data),
        .lnk_rsp_unsol(lnk_rsp_unsol), .lnk_rsp_caddr(lnk_rsp_caddr),
        .lnk_rsp_ready(lnk_rsp_ready)
    );

    function automatic logic [7:0] size_mask(input logic [1:0] sel);
        if (sel == 2'd0) return 8'd1;
        if (sel == 2'd1) return 8'd15;
        return 8'd255;
    endfunction

    // memory stand-in: one access per request, acknowledged a cycle later
    always @(posedge clk) begin
        if (rst) begin
            mem_ack   <= 1'b0;
            mem_rdata <= '0;
        end else begin
            mem_ack <= 1'b0;
            if (mem_req && !mem_ack) begin
                mem_ack <= 1'b1;
                if (mem_we)
                    wr_log.push_back('{addr: mem_addr, data: mem_wdata});
                else
                    mem_rdata <= cmd_mem[8'(mem_addr - AW'(CMD_BASE))];
            end
        end
    end

    // codec link stand-in plus reference pointers
    always @(posedge clk) begin
        if (rst) begin
            lnk_cmd_ready <= 1'b1;
            lnk_rsp_valid <= 1'b0;
            lnk_rsp_data  <= '0;
            lnk_rsp_unsol <= 1'b0;
            lnk_rsp_caddr <= '0;
            lnk_busy      <= 1'b0;
            lat_cnt       <= 0;
            pend_cmd      <= '0;
            unsol_done    <= 0;
            model_rp      <= '0;
            model_wp      <= '0;
            model_out     <= 1'b0;
        end else begin
            if (cmd_rp_rst)
                model_rp <= '0;
            else if (lnk_cmd_valid && lnk_cmd_ready) begin
                model_rp <= (model_rp + 8'd1) & size_mask(cmd_size_sel);
                got_cmds.push_back(lnk_cmd);
                pend_cmd  <= lnk_cmd;
                lnk_busy  <= 1'b1;
                lat_cnt   <= LINK_LAT;
                model_out <= 1'b1;
            end
            if (rsp_wp_rst)
                model_wp <= '0;
            if (lnk_rsp_valid && lnk_rsp_ready) begin
                exp_rsp.push_back('{slot: (model_wp + 8'd1) & size_mask(rsp_size_sel),
                                    data: lnk_rsp_data,
                                    ext: {27'd0, lnk_rsp_unsol, lnk_rsp_caddr}});
                model_wp <= (model_wp + 8'd1) & size_mask(rsp_size_sel);
                if (!lnk_rsp_unsol) model_out <= 1'b0;
                lnk_rsp_valid <= 1'b0;
            end else if (!lnk_rsp_valid) begin
                if (lnk_busy && lat_cnt == 0) begin
                    lnk_rsp_valid <= 1'b1;
                    lnk_rsp_data  <= pend_cmd ^ 32'h5A5A_5A5A;
                    lnk_rsp_unsol <= 1'b0;
                    lnk_rsp_caddr <= pend_cmd[31:28];
                    lnk_busy      <= 1'b0;
                end else if (unsol_reqs > unsol_done) begin
                    lnk_rsp_valid <= 1'b1;
                    lnk_rsp_data  <= 32'hC0DE_0000 + 32'(unsol_done);
                    lnk_rsp_unsol <= 1'b1;
                    lnk_rsp_caddr <= UNSOL_ADDR;
                    unsol_done    <= unsol_done + 1;
                end
            end
            if (lnk_busy && lat_cnt > 0 && !(lnk_cmd_valid && lnk_cmd_ready))
                lat_cnt <= lat_cnt - 1;
        end
    end

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // per-clock comparison against the reference model
    always @(negedge clk) begin
        if (!rst && !finished) begin
            check("R2 read pointer vs model", 32'(cmd_rp), 32'(model_rp));
            if (lnk_cmd_valid) check("R5 command while one outstanding", 32'(model_out), 32'd0);
        end
    end

    task automatic push_cmd(input logic [31:0] w);
        logic [7:0] slot;
        slot = (sw_wp + 8'd1) & size_mask(cmd_size_sel);
        cmd_mem[slot] = w;
        exp_cmds.push_back(w);
        sw_wp  = slot;
        cmd_wp = sw_wp;
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic verify_cmds();
        check("R1 command count", 32'(got_cmds.size()), 32'(exp_cmds.size()));
        while (exp_cmds.size() > 0 && got_cmds.size() > 0)
            check("R1 command word", got_cmds.pop_front(), exp_cmds.pop_front());
        exp_cmds.delete();
        got_cmds.delete();
    endtask

    task automatic verify_rsps();
        exp_rsp_t e;
        wr_t w;
        while (exp_rsp.size() > 0) begin
            e = exp_rsp.pop_front();
            if (wr_log.size() < 2) begin
                check("R6 response writes missing", 32'(wr_log.size()), 32'd2);
                wr_log.delete();
            end else begin
                w = wr_log.pop_front();
                check("R6 data word address", 32'(w.addr), 32'(RSP_BASE + 2 * int'(e.slot)));
                check("R6 data word", w.data, e.data);
                w = wr_log.pop_front();
                check("R6 ext word address", 32'(w.addr), 32'(RSP_BASE + 2 * int'(e.slot) + 1));
                check("R6 ext word", w.data, e.ext);
            end
        end
        check("R6 no extra writes", 32'(wr_log.size()), 32'd0);
        wr_log.delete();
    endtask

    task automatic clear_irq();
        rsp_irq_clr = 1'b1;
        @(negedge clk);
        rsp_irq_clr = 1'b0;
        @(negedge clk);
        check("R8 status cleared by write-1", 32'(rsp_irq), 32'd0);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) cmd_mem[i] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // reset state
        check("R2 reset read pointer", 32'(cmd_rp), 32'd0);
        check("R6 reset write pointer", 32'(rsp_wp), 32'd0);
        check("R8 reset status", 32'(rsp_irq), 32'd0);
        check("R4 reset readback", 32'(cmd_rp_rst_busy), 32'd0);
        check("R3 size capability", 32'(size_cap), 32'd7);
        check("R10 no request after reset", 32'(mem_req | lnk_cmd_valid), 32'd0);

        // 256-entry rings, command ring stopped first
        rsp_run = 1'b1;
        rsp_int_cnt = 8'd3;
        push_cmd(32'h1_0A_F0000);
        push_cmd(32'h2_14_70500);
        settle(60);
        check("R10 nothing sent while stopped", 32'(got_cmds.size()), 32'd0);
        check("R10 read pointer held while stopped", 32'(cmd_rp), 32'd0);
        check("R10 no fetch while stopped", 32'(mem_req), 32'd0);
        cmd_run = 1'b1;
        push_cmd(32'hF_FF_FFFFF);
        settle(80);
        verify_cmds();
        check("R2 read pointer after three", 32'(cmd_rp), 32'd3);
        check("R6 write pointer after three", 32'(rsp_wp), 32'd3);
        verify_rsps();
        check("R8 status after count reached", 32'(rsp_irq), 32'd1);
        clear_irq();

        // unsolicited response while idle
        unsol_reqs++;
        settle(30);
        verify_rsps();
        check("R6 pointer after unsolicited", 32'(rsp_wp), 32'd4);
        check("R5 unsolicited sends no command", 32'(got_cmds.size()), 32'd0);
        check("R8 no status before count", 32'(rsp_irq), 32'd0);

        // response ring stopped
        rsp_run = 1'b0;
        unsol_reqs++;
        settle(40);
        check("R9 nothing written while stopped", 32'(wr_log.size()), 32'd0);
        check("R9 pointer held while stopped", 32'(rsp_wp), 32'd4);
        check("R9 link not accepted while stopped", 32'(lnk_rsp_ready), 32'd0);
        rsp_run = 1'b1;
        settle(30);
        verify_rsps();
        check("R9 stored after restart", 32'(rsp_wp), 32'd5);

        // pointer reset controls
        cmd_run = 1'b0;
        cmd_rp_rst = 1'b1;
        @(negedge clk);
        check("R4 pointer zero during reset", 32'(cmd_rp), 32'd0);
        check("R4 readback set", 32'(cmd_rp_rst_busy), 32'd1);
        cmd_rp_rst = 1'b0;
        sw_wp = 8'd0;
        cmd_wp = 8'd0;
        @(negedge clk);
        check("R4 readback cleared", 32'(cmd_rp_rst_busy), 32'd0);
        rsp_wp_rst = 1'b1;
        @(negedge clk);
        rsp_wp_rst = 1'b0;
        check("R7 write pointer zero", 32'(rsp_wp), 32'd0);

        // 2-entry rings, one command at a time across the wrap
        cmd_size_sel = 2'd0;
        rsp_size_sel = 2'd0;
        rsp_int_cnt = 8'd1;
        cmd_run = 1'b1;
        for (int i = 0; i < 4; i++) begin
            push_cmd(32'h30000000 + 32'(i * 32'h111));
            settle(40);
            verify_cmds();
            check("R3 read pointer wraps at 2", 32'(cmd_rp), 32'((i + 1) % 2));
            check("R3 write pointer wraps at 2", 32'(rsp_wp), 32'((i + 1) % 2));
            verify_rsps();
            check("R8 status with count of one", 32'(rsp_irq), 32'd1);
            clear_irq();
        end

        // 16-entry rings, burst longer than the ring, unsolicited mixed in
        cmd_size_sel = 2'd1;
        rsp_size_sel = 2'd1;
        rsp_int_cnt = 8'd5;
        for (int i = 0; i < 10; i++) push_cmd(32'h4_20_00000 + 32'(i));
        settle(25);
        unsol_reqs++;
        settle(250);
        for (int i = 0; i < 7; i++) push_cmd(32'h5_30_00000 + 32'(i));
        settle(200);
        verify_cmds();
        check("R3 read pointer wraps at 16", 32'(cmd_rp), 32'd1);
        check("R3 write pointer wraps at 16", 32'(rsp_wp), 32'd2);
        verify_rsps();
        check("R8 status after several counts", 32'(rsp_irq), 32'd1);

        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule